// File: doc/BRIEF.md
# Unsigned integer to binary64 converter

This unit turns an unsigned integer into an IEEE 754 double-precision value. The integer is either 32 or 64 bits wide. The converted value fills the low 64 bits of a 128-bit vector result. The high 64 bits of that result pass through unchanged from a separate vector operand. The conversion logic is combinational and feeds a single output register, so a result appears one clock after its operands.

The full 64-bit integer is converted only when the core is in 64-bit mode and the operand-width bit asks for a wide input. In every other case only the low 32 bits are used, and those always convert exactly. The rounding direction has two possible sources:
- A per-operation override. It applies only on the wide path, only when the operand comes from a register and only when the override is enabled.
- A global control field, used in every other case.

The only condition the unit reports is inexact.

Top module: `u2f64_cvt`

## Requirements
- R1: With `long_mode_i` and `wide_op_i` both 1, all 64 bits of `int_src_i` are converted. The output is a binary64 value: sign bit 63, an 11-bit exponent in bits 62:52 with bias 1023, and a 52-bit fraction in bits 51:0.
- R2: When `long_mode_i` or `wide_op_i` is 0, only `int_src_i[31:0]` is converted and bits 63:32 have no effect. With `long_mode_i` at 0, the value of `wide_op_i` has no effect.
- R3: The rounding code is `rc_embed_i` when the wide path is active and both `src_is_reg_i` and `rc_ovr_en_i` are 1. Otherwise it is `rc_global_i`.
- R4: Rounding codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. Ties under 00 go to the even significand.
- R5: `result_o[127:64]` equals `vec_src_i[127:64]` from the same cycle.
- R6: A zero operand yields `result_o[63:0]` of all zeros with `inexact_o` at 0. The sign bit `result_o[63]` is always 0.
- R7: `inexact_o` is 1 exactly when the selected operand is not representable in 53 significant bits. It is never 1 on the 32-bit path.
- R8: A rounding carry out of the fraction raises the exponent by one. All-ones 64-bit input rounded upward gives 0x43F0000000000000 (2^64).
- R9: Outputs are registered, with one clock of latency. While `rst_n` is low, `result_o` and `inexact_o` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| vec_src_i | input | 128 | Vector operand; bits 127:64 are merged into the result |
| int_src_i | input | 64 | Unsigned integer operand |
| long_mode_i | input | 1 | Core runs in 64-bit mode |
| wide_op_i | input | 1 | Operand width request: 1 = 64-bit |
| rc_ovr_en_i | input | 1 | Enable for the per-operation rounding override |
| src_is_reg_i | input | 1 | Integer operand comes from a register |
| rc_embed_i | input | 2 | Per-operation rounding code |
| rc_global_i | input | 2 | Global rounding code |
| result_o | output | 128 | Converted value in 63:0, merged vector lane in 127:64 |
| inexact_o | output | 1 | Precision flag |

## Verification
The hardest case to reach is a rounding carry that ripples through all 52 fraction bits into the exponent. Only operands whose top 53 bits are all ones and whose discarded bits request an increment produce it. Random inputs almost never hit it. The bench sweeps all-ones patterns of every length and exact halfway patterns at every shift distance, each under all four rounding codes. This lands on ties and on carries at each exponent, and it also covers operands that convert exactly.

// File: rtl/u2f_pkg.sv
package u2f_pkg;

  localparam int INT_W  = 64;
  localparam int NARROW_W = 32;
  localparam int FRAC_W = 52;
  localparam int EXP_W  = 11;
  localparam int BIAS   = 1023;

  typedef enum logic [1:0] {
    RM_NEAREST = 2'b00,
    RM_DOWN    = 2'b01,
    RM_UP      = 2'b10,
    RM_ZERO    = 2'b11
  } rmode_e;

  // increment decision for a positive magnitude
  function automatic logic round_inc(rmode_e mode, logic lsb, logic g,
                                     logic r, logic s);
    logic inc;
    unique case (mode)
      RM_NEAREST: inc = g & (r | s | lsb);
      RM_UP:      inc = g | r | s;
      default:    inc = 1'b0;
    endcase
    return inc;
  endfunction

endpackage

// File: rtl/u2f_opsel.sv
module u2f_opsel
  import u2f_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int NW = NARROW_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] int_src_i,
  input  logic          long_mode_i,
  input  logic          wide_op_i,
  input  logic          rc_ovr_en_i,
  input  logic          src_is_reg_i,
  input  logic [1:0]    rc_embed_i,
  input  logic [1:0]    rc_global_i,
  output logic [IW-1:0] operand_o,
  output logic          wide_sel_o,
  output rmode_e        rmode_o
);

  logic use_embed;

  always_comb begin
    wide_sel_o = long_mode_i & wide_op_i;
    if (wide_sel_o) operand_o = int_src_i;
    else            operand_o = {{(IW-NW){1'b0}}, int_src_i[NW-1:0]};
    use_embed = wide_sel_o & src_is_reg_i & rc_ovr_en_i;
    rmode_o   = use_embed ? rmode_e'(rc_embed_i) : rmode_e'(rc_global_i);
  end

  // narrow path must never take the per-operation code
  assert_narrow_global_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_sel_o |-> (rmode_o == rmode_e'(rc_global_i)));

  assert_narrow_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !wide_sel_o |-> (operand_o[IW-1:NW] == '0));

endmodule

// File: rtl/u2f_norm.sv
module u2f_norm
  import u2f_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int FW = FRAC_W,
  parameter int EW = EXP_W,
  parameter int BS = BIAS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [IW-1:0] operand_i,
  output logic          is_zero_o,
  output logic [EW-1:0] exp_o,
  output logic [FW-1:0] frac_o,
  output logic          guard_o,
  output logic          round_o,
  output logic          sticky_o
);

  localparam int LZ_W = $clog2(IW + 1);
  localparam int SPARE = IW - 1 - FW;

  function automatic logic [LZ_W-1:0] lead_zeros(logic [IW-1:0] v);
    logic [LZ_W-1:0] n;
    logic            seen;
    n = LZ_W'(IW);
    seen = 1'b0;
    for (int i = IW - 1; i >= 0; i--) begin
      if (v[i] && !seen) begin
        n = LZ_W'(IW - 1 - i);
        seen = 1'b1;
      end
    end
    return n;
  endfunction

  logic [LZ_W-1:0] lz;
  logic [IW-1:0]   shifted;

  always_comb begin
    lz        = lead_zeros(operand_i);
    is_zero_o = (operand_i == '0);
    shifted   = operand_i << lz;
    exp_o     = is_zero_o ? '0 : (EW'(BS + IW - 1) - EW'(lz));
    frac_o    = shifted[IW-2 -: FW];
  end

  // discarded bits: guard, round, sticky (variant picked by width)
  generate
    if (SPARE >= 3) begin : g_grs
      assign guard_o  = shifted[SPARE-1];
      assign round_o  = shifted[SPARE-2];
      assign sticky_o = |shifted[SPARE-3:0];
    end else if (SPARE == 2) begin : g_gr
      assign guard_o  = shifted[1];
      assign round_o  = shifted[0];
      assign sticky_o = 1'b0;
    end else begin : g_exact
      assign guard_o  = 1'b0;
      assign round_o  = 1'b0;
      assign sticky_o = 1'b0;
    end
  endgenerate

  // a nonzero operand is normalized: its top bit is the hidden one
  assert_normalized_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !is_zero_o |-> shifted[IW-1]);

endmodule

// File: rtl/u2f_round.sv
module u2f_round
  import u2f_pkg::*;
#(
  parameter int FW = FRAC_W,
  parameter int EW = EXP_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [EW-1:0]    exp_i,
  input  logic [FW-1:0]    frac_i,
  input  logic             guard_i,
  input  logic             round_i,
  input  logic             sticky_i,
  input  rmode_e           rmode_i,
  output logic [EW+FW:0]   packed_o,
  output logic             inexact_o,
  output logic             carry_evt_o
);

  logic            inc;
  logic [EW+FW-1:0] mag;

  always_comb begin
    inc         = round_inc(rmode_i, frac_i[0], guard_i, round_i, sticky_i);
    mag         = {exp_i, frac_i} + (EW+FW)'(inc);
    inexact_o   = guard_i | round_i | sticky_i;
    carry_evt_o = inc & (&frac_i);
    packed_o    = {1'b0, mag};
  end

  assert_carry_bumps_exp_R8: assert property (@(posedge clk) disable iff (!rst_n)
    carry_evt_o |-> (packed_o[EW+FW-1:FW] == exp_i + EW'(1)) && (packed_o[FW-1:0] == '0));

  assert_exact_no_change_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !inexact_o |-> (packed_o[EW+FW-1:0] == {exp_i, frac_i}));

endmodule

// File: rtl/u2f64_cvt.sv
module u2f64_cvt
  import u2f_pkg::*;
#(
  parameter int IW = INT_W,
  parameter int NW = NARROW_W,
  parameter int FW = FRAC_W,
  parameter int EW = EXP_W,
  parameter int BS = BIAS
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [2*(EW+FW+1)-1:0] vec_src_i,
  input  logic [IW-1:0]        int_src_i,
  input  logic                 long_mode_i,
  input  logic                 wide_op_i,
  input  logic                 rc_ovr_en_i,
  input  logic                 src_is_reg_i,
  input  logic [1:0]           rc_embed_i,
  input  logic [1:0]           rc_global_i,
  output logic [2*(EW+FW+1)-1:0] result_o,
  output logic                 inexact_o
);

  localparam int LANE = EW + FW + 1;

  logic [IW-1:0] operand;
  logic          wide_sel;
  rmode_e        rmode;
  logic          is_zero;
  logic [EW-1:0] exp_b;
  logic [FW-1:0] frac;
  logic          g, r, s;
  logic [LANE-1:0] packed_val;
  logic          inexact_raw;
  logic          carry_evt;
  logic          past_ok;

  u2f_opsel #(.IW(IW), .NW(NW)) opsel_i (
    .clk(clk), .rst_n(rst_n),
    .int_src_i(int_src_i), .long_mode_i(long_mode_i), .wide_op_i(wide_op_i),
    .rc_ovr_en_i(rc_ovr_en_i), .src_is_reg_i(src_is_reg_i),
    .rc_embed_i(rc_embed_i), .rc_global_i(rc_global_i),
    .operand_o(operand), .wide_sel_o(wide_sel), .rmode_o(rmode)
  );

  u2f_norm #(.IW(IW), .FW(FW), .EW(EW), .BS(BS)) norm_i (
    .clk(clk), .rst_n(rst_n), .operand_i(operand),
    .is_zero_o(is_zero), .exp_o(exp_b), .frac_o(frac),
    .guard_o(g), .round_o(r), .sticky_o(s)
  );

  u2f_round #(.FW(FW), .EW(EW)) round_i (
    .clk(clk), .rst_n(rst_n), .exp_i(exp_b), .frac_i(frac),
    .guard_i(g), .round_i(r), .sticky_i(s), .rmode_i(rmode),
    .packed_o(packed_val), .inexact_o(inexact_raw), .carry_evt_o(carry_evt)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      result_o  <= '0;
      inexact_o <= 1'b0;
      past_ok   <= 1'b0;
    end else begin
      result_o  <= {vec_src_i[2*LANE-1:LANE], packed_val};
      inexact_o <= inexact_raw;
      past_ok   <= 1'b1;
    end
  end

  assert_upper_merge_R5: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok |-> (result_o[2*LANE-1:LANE] == $past(vec_src_i[2*LANE-1:LANE])));

  assert_sign_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    result_o[LANE-1] == 1'b0);

  assert_zero_in_R6: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(is_zero) |-> (result_o[LANE-1:0] == '0) && !inexact_o);

  assert_narrow_exact_R7: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && !$past(wide_sel) |-> !inexact_o);

  assert_carry_lands_R8: assert property (@(posedge clk) disable iff (!rst_n)
    past_ok && $past(carry_evt) |-> (result_o[FW-1:0] == '0) && inexact_o);

endmodule

// File: tb/u2f64_cvt_tb_top.sv
`timescale 1ns/1ps
module u2f64_cvt_tb_top;

  logic         clk = 1'b0;
  logic         rst_n;
  logic [127:0] vec_src;
  logic [63:0]  int_src;
  logic         long_mode, wide_op, ovr_en, is_reg;
  logic [1:0]   rc_emb, rc_glb;
  logic [127:0] result;
  logic         inexact;

  int nchk = 0;
  int nerr = 0;
  bit done = 0;

  always #2 clk = ~clk;

  u2f64_cvt dut_i (
    .clk(clk), .rst_n(rst_n), .vec_src_i(vec_src), .int_src_i(int_src),
    .long_mode_i(long_mode), .wide_op_i(wide_op), .rc_ovr_en_i(ovr_en),
    .src_is_reg_i(is_reg), .rc_embed_i(rc_emb), .rc_global_i(rc_glb),
    .result_o(result), .inexact_o(inexact)
  );

  // reference: exact integer division view of the rounding
  function automatic logic [63:0] ref_bits(logic [63:0] x, logic [1:0] m,
                                           output logic inx);
    int p;
    int sh;
    logic [63:0] q, rem, half;
    logic up;
    inx = 1'b0;
    if (x == 64'd0) return 64'd0;
    p = 0;
    for (int i = 0; i < 64; i++) if (x[i]) p = i;
    if (p <= 52) begin
      q = x << (52 - p);
    end else begin
      sh   = p - 52;
      q    = x >> sh;
      rem  = x & ((64'd1 << sh) - 64'd1);
      half = 64'd1 << (sh - 1);
      inx  = (rem != 64'd0);
      case (m)
        2'b00:   up = (rem > half) || (rem == half && q[0]);
        2'b10:   up = (rem != 64'd0);
        default: up = 1'b0;
      endcase
      q = q + {63'd0, up};
      if (q[53]) begin
        q = q >> 1;
        p = p + 1;
      end
    end
    return {1'b0, 11'(p + 1023), q[51:0]};
  endfunction

  task automatic check(string tag, string what, logic [63:0] act, logic [63:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  task automatic run(string tag, logic [63:0] x, logic lm, logic w, logic en,
                     logic rg, logic [1:0] emb, logic [1:0] glb);
    logic [63:0]  opnd;
    logic [1:0]   m;
    logic [63:0]  exp_low;
    logic         exp_inx;
    logic [63:0]  hi;
    @(negedge clk);
    hi = {x[31:0] ^ 32'hA5A5_5A5A, x[63:32] + 32'd7};
    vec_src = {hi, ~x};
    int_src = x; long_mode = lm; wide_op = w; ovr_en = en; is_reg = rg;
    rc_emb = emb; rc_glb = glb;
    opnd = (lm && w) ? x : {32'd0, x[31:0]};
    m    = (lm && w && en && rg) ? emb : glb;
    exp_low = ref_bits(opnd, m, exp_inx);
    @(negedge clk);
    check(tag, "low lane", result[63:0], exp_low);
    check("R5", "upper lane", result[127:64], hi);
    check("R7", "inexact", {63'd0, inexact}, {63'd0, exp_inx});
  endtask

  initial begin
    #(4 * 150000);
    if (!done) begin
      nerr++; nchk++;
      $display("FAIL R9 watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", nerr, nchk);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0;
    vec_src = '1; int_src = '1; long_mode = 1; wide_op = 1;
    ovr_en = 0; is_reg = 0; rc_emb = 0; rc_glb = 0;
    repeat (3) @(negedge clk);
    check("R9", "reset result", result[63:0], 64'd0);
    check("R9", "reset upper", result[127:64], 64'd0);
    check("R9", "reset inexact", {63'd0, inexact}, 64'd0);
    rst_n = 1'b1;

    // R1 / R4 / R8: powers of two and all-ones runs in every mode
    for (int m = 0; m < 4; m++) begin
      for (int k = 0; k < 64; k++) begin
        run("R1", 64'd1 << k, 1, 1, 0, 1, 2'b00, 2'(m));
        run("R8", (k == 63) ? '1 : ((64'd1 << (k + 1)) - 64'd1), 1, 1, 0, 0, 2'b00, 2'(m));
      end
    end

    // R4: halfway and near-halfway tails, even and odd significands
    for (int m = 0; m < 4; m++) begin
      for (int sh = 1; sh <= 11; sh++) begin
        for (int par = 0; par < 2; par++) begin
          logic [63:0] base;
          logic [63:0] hv;
          base = ((64'd1 << 52) | 64'h0_1234_5678_9AB0 | 64'(par)) << sh;
          hv   = 64'd1 << (sh - 1);
          run("R4", base + hv, 1, 1, 0, 0, 2'b00, 2'(m));
          if (sh > 1) begin
            run("R4", base + hv - 64'd1, 1, 1, 0, 0, 2'b00, 2'(m));
            run("R4", base + hv + 64'd1, 1, 1, 0, 0, 2'b00, 2'(m));
          end
        end
      end
    end

    // R2: narrow path, upper integer bits and width bit must not matter
    for (int k = 0; k < 32; k++) begin
      run("R2", {32'hDEAD_BEEF, 32'd1 << k}, 1, 0, 1, 1, 2'b10, 2'b11);
      run("R2", {32'hFFFF_FFFF, 32'hFFFF_FFFF >> k}, 0, 1, 1, 1, 2'b10, 2'b00);
      run("R7", {32'h8000_0001, 32'hFFFF_FFFF - 32'(k)}, 0, 0, 0, 0, 2'b00, 2'b10);
    end

    // R3: source of the rounding code, on a value that rounds differently
    run("R3", '1, 1, 1, 1, 1, 2'b11, 2'b00);
    check("R3", "embedded toward zero", result[63:0], 64'h43EF_FFFF_FFFF_FFFF);
    run("R3", '1, 1, 1, 1, 0, 2'b11, 2'b00);
    check("R3", "memory source uses global", result[63:0], 64'h43F0_0000_0000_0000);
    run("R3", '1, 1, 1, 0, 1, 2'b11, 2'b00);
    check("R3", "override off uses global", result[63:0], 64'h43F0_0000_0000_0000);
    run("R8", '1, 1, 1, 0, 0, 2'b00, 2'b10);
    check("R8", "all ones upward", result[63:0], 64'h43F0_0000_0000_0000);

    // R6: zero in every mode and path
    for (int m = 0; m < 4; m++) begin
      run("R6", 64'd0, 1, 1, 1, 1, 2'(m), 2'(m));
      run("R6", 64'hFFFF_FFFF_0000_0000, 1, 0, 0, 0, 2'b00, 2'(m));
    end

    // R9: output holds until the next clock edge
    @(negedge clk);
    int_src = 64'd5; long_mode = 1; wide_op = 1; rc_glb = 2'b00;
    #1;
    check("R9", "holds before edge", result[63:0], 64'd0);
    @(negedge clk);
    check("R9", "one-cycle latency", result[63:0], 64'h4014_0000_0000_0000);

    done = 1;
    $display("Result: errors=%0d of %0d checks", nerr, nchk);
    $finish;
  end

endmodule